// File: doc/BRIEF.md
# Queued Conversion Sequencer

This block steps an analog-to-digital converter through a list of conversion commands held in a small command RAM. It reads one command word at a time. For each word it times an initial buffered sample phase and then a final direct sample phase of selectable length. It then hands the converter a start pulse and waits for the converter's done strobe. The returned value goes into a result RAM at the same index as the command that produced it.

The command RAM is split into two queues. A boundary input sets where the second queue begins. Each queue has its own trigger, an arm bit, a scan mode, and pause, completion and overrun flags. Queue 1 takes precedence over queue 2 at command boundaries. A queue stops at three kinds of end: an end-marker channel code, the boundary index for queue 1, or the top of the RAM. Pause bits inside command words split a pass into pieces, and each piece after the first starts on a new trigger.

Top module: `qadc_seq`

## Requirements
- R1: After reset, every flag, arm bit, active bit, `irq`, `cnv_start` and `res_we` is 0 and `cnv_phase` is 0 (idle).
- R2: Each command runs `cnv_phase`=1 for INIT_CYC cycles, then `cnv_phase`=2, then `cnv_phase`=3. `cnv_start` is high for exactly one cycle, on the first cycle of phase 3, and phase 3 lasts until `cnv_done`.
- R3: The command word is laid out as bit 8 = pause, bits 7:6 = sample code, bits 5:0 = channel. Sample code 0, 1, 2 and 3 gives a phase-2 length of 2, 4, 8 and 16 cycles.
- R4: The cycle after `cnv_done`, `res_we` pulses with `res_addr` equal to the command's index and `res_data` equal to `cnv_data`. The queue pointer then moves to the next index.
- R5: A command with its pause bit set is converted and written. Its queue then halts and sets its pause flag. The next trigger to that queue resumes at the following index.
- R6: A word whose channel field is 63 ends the queue. No conversion starts for it, and the queue's done flag is set.
- R7: Queue 1 covers indices 0 up to `bq2`-1 and queue 2 covers `bq2` up to DEPTH-1. A `bq2` value above DEPTH acts as DEPTH.
- R8: A queue also ends after converting index DEPTH-1.
- R9: In single-scan mode (`cont`=0), an end clears the queue's arm bit, and triggers are ignored until `en_set`. In continuous mode the arm bit stays set and a new pass starts at once from the queue's first index. A pass that ends while the queue is disarmed stops the queue.
- R10: A queue 1 trigger while queue 2 runs takes effect after queue 2's current command. Queue 1 then runs to its end, and queue 2 resumes at its next index.
- R11: A trigger to an armed queue that is active and not paused sets that queue's overrun flag and has no other effect. A trigger to an unarmed queue does nothing.
- R12: `irq` is the OR of (pause flag AND `pause_ie`) and (done flag AND `done_ie`) over both queues. `flag_clr` bits [1:0] clear the pause flags, [3:2] the done flags and [5:4] the overrun flags. Bit 0 of each pair belongs to queue 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 2 | Trigger pulse per queue (bit 0 = queue 1) |
| en_set | input | 2 | Arm a queue |
| en_clr | input | 2 | Disarm a queue |
| cont | input | 2 | 1 = continuous scan, 0 = single scan |
| bq2 | input | AW+1 | First index of queue 2 |
| pause_ie | input | 2 | Interrupt enable for the pause flags |
| done_ie | input | 2 | Interrupt enable for the done flags |
| flag_clr | input | 6 | Flag clear strobes |
| cmd_addr | output | AW | Command RAM read address |
| cmd_word | input | 9 | Command RAM read data (same cycle) |
| res_we | output | 1 | Result RAM write strobe |
| res_addr | output | AW | Result RAM write address |
| res_data | output | RES_W | Result RAM write data |
| cnv_phase | output | 2 | 0 idle, 1 initial sample, 2 final sample, 3 resolve |
| cnv_start | output | 1 | Converter start pulse |
| cnv_chan | output | 6 | Channel of the current command |
| cnv_done | input | 1 | Converter done strobe |
| cnv_data | input | RES_W | Converter result |
| q_active | output | 2 | Queue is mid-pass, paused or not |
| q_en | output | 2 | Queue arm bits |
| pause_flag | output | 2 | Pause flags |
| done_flag | output | 2 | Done flags |
| overrun_flag | output | 2 | Trigger overrun flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=8 and INIT_CYC=2. At that size every command index, the queue boundary and the top of the RAM can be reached in a few hundred cycles. It sweeps all four sample codes and checks the phase lengths it counts against the 2<<code rule. It fills the whole RAM so that ending at the top is covered. It sets the boundary inside the RAM so that the implicit end of queue 1 and the start of queue 2 are both exercised. It also interleaves the two queues and compares the write order it logs against a sequence it computes itself.

// File: rtl/qseq_pkg.sv
// Package: shared types for the queued conversion sequencer.
// Assumes a 9-bit command word with a 6-bit channel field.
package qseq_pkg;
    localparam int CH_W   = 6;
    localparam int CMD_W  = 9;

    typedef struct packed {
        logic       pause;
        logic [1:0] stime;
        logic [5:0] chan;
    } ccw_t;

    typedef enum logic [2:0] {
        S_DISP, S_INIT, S_FINAL, S_START, S_WAIT, S_WRITE
    } seq_st_e;
endpackage

// File: rtl/qseq_queue.sv
// Module: per-queue control. Holds the pointer, the active/hold state,
// the arm bit and the three flags of one queue.
// Assumes the engine raises ev_end only for an active queue and ev_adv
// only for an active, unheld queue.
module qseq_queue #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig,
    input  logic        en_set,
    input  logic        en_clr,
    input  logic        cont,
    input  logic [AW:0] start_idx,
    input  logic        ev_end,
    input  logic        ev_adv,
    input  logic        ev_pause,
    input  logic        clr_pf,
    input  logic        clr_cf,
    input  logic        clr_tor,
    output logic        run,
    output logic        hold,
    output logic [AW:0] ptr,
    output logic        en,
    output logic        pf,
    output logic        cf,
    output logic        tor
);
    // Queue state update: clears first, so a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            hold <= 1'b0;
            ptr  <= '0;
            en   <= 1'b0;
            pf   <= 1'b0;
            cf   <= 1'b0;
            tor  <= 1'b0;
        end else begin
            if (clr_pf)  pf  <= 1'b0;
            if (clr_cf)  cf  <= 1'b0;
            if (clr_tor) tor <= 1'b0;

            if (en_set)
                en <= 1'b1;
            else if (en_clr || (ev_end && !cont))
                en <= 1'b0;

            if (ev_end) begin
                ptr <= start_idx;
                cf  <= 1'b1;
                run <= cont && en && !en_clr;
            end else if (ev_adv) begin
                ptr <= ptr + 1'b1;
                if (ev_pause) begin
                    hold <= 1'b1;
                    pf   <= 1'b1;
                end
            end

            if (trig && en) begin
                if (!run) begin
                    run <= 1'b1;
                    ptr <= start_idx;
                end else if (hold) begin
                    hold <= 1'b0;
                end else begin
                    tor <= 1'b1;
                end
            end
        end
    end

    a_r5_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_adv && ev_pause) |=> (hold && pf));

    a_r11_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && en && run && !hold) |=> tor);

    a_r9_single_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_end && !cont && !en_set) |=> !en);

    a_r8_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= (AW+1)'(DEPTH));
endmodule

// File: rtl/qseq_engine.sv
// Module: conversion engine. Picks the ready queue (queue 1 first) at each
// command boundary, detects end of queue, times the two sample phases,
// runs the converter handshake and writes the result.
// Assumes the command RAM reads combinationally and cnv_done arrives
// no earlier than the cycle after cnv_start.
module qseq_engine
    import qseq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int AW       = $clog2(DEPTH),
    parameter int RES_W    = 10,
    parameter int INIT_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       q_run,
    input  logic [1:0]       q_hold,
    input  logic [AW:0]      ptr_a,
    input  logic [AW:0]      ptr_b,
    input  logic [AW:0]      lim_a,
    input  logic [AW:0]      lim_b,
    output logic [AW-1:0]    cmd_addr,
    input  logic [CMD_W-1:0] cmd_word,
    output logic [1:0]       ev_end,
    output logic [1:0]       ev_adv,
    output logic             ev_pause,
    output logic [1:0]       phase,
    output logic             cnv_start,
    output logic [CH_W-1:0]  cnv_chan,
    input  logic             cnv_done,
    input  logic [RES_W-1:0] cnv_data,
    output logic             res_we,
    output logic [AW-1:0]    res_addr,
    output logic [RES_W-1:0] res_data
);
    localparam int MAXC  = (INIT_CYC > 16) ? INIT_CYC : 16;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_st_e          state;
    logic [CNT_W-1:0] cnt;
    logic             cur_q;
    logic [AW-1:0]    cur_idx;
    ccw_t             cur;
    logic [RES_W-1:0] rdata;

    logic [1:0]  rdy;
    logic        any_rdy;
    logic        sel_q;
    logic [AW:0] sel_ptr;
    logic [AW:0] sel_lim;
    ccw_t        word;
    logic        at_end;

    // Queue selection and end-of-queue detection at the command boundary.
    always_comb begin
        rdy      = q_run & ~q_hold;
        any_rdy  = |rdy;
        sel_q    = !rdy[0];
        sel_ptr  = sel_q ? ptr_b : ptr_a;
        sel_lim  = sel_q ? lim_b : lim_a;
        cmd_addr = (state == S_DISP) ? sel_ptr[AW-1:0] : cur_idx;
        word     = ccw_t'(cmd_word);
        at_end   = (sel_ptr >= sel_lim) || (word.chan == '1);
    end

    // Event strobes and converter-side outputs decoded from the state.
    always_comb begin
        ev_end    = (state == S_DISP && any_rdy && at_end) ? (2'b01 << sel_q) : 2'b00;
        ev_adv    = (state == S_WRITE) ? (2'b01 << cur_q) : 2'b00;
        ev_pause  = (state == S_WRITE) && cur.pause;
        cnv_start = (state == S_START);
        cnv_chan  = cur.chan;
        res_we    = (state == S_WRITE);
        res_addr  = cur_idx;
        res_data  = rdata;
        unique case (state)
            S_INIT:          phase = 2'd1;
            S_FINAL:         phase = 2'd2;
            S_START, S_WAIT: phase = 2'd3;
            default:         phase = 2'd0;
        endcase
    end

    // Command sequencing: latch the command, time the phases, capture data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_DISP;
            cnt     <= '0;
            cur_q   <= 1'b0;
            cur_idx <= '0;
            cur     <= '0;
            rdata   <= '0;
        end else begin
            unique case (state)
                S_DISP: begin
                    if (any_rdy && !at_end) begin
                        cur_q   <= sel_q;
                        cur_idx <= sel_ptr[AW-1:0];
                        cur     <= word;
                        cnt     <= CNT_W'(INIT_CYC - 1);
                        state   <= S_INIT;
                    end
                end
                S_INIT: begin
                    if (cnt == '0) begin
                        cnt   <= CNT_W'((32'd2 << cur.stime) - 32'd1);
                        state <= S_FINAL;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_FINAL: begin
                    if (cnt == '0) state <= S_START;
                    else           cnt   <= cnt - 1'b1;
                end
                S_START: state <= S_WAIT;
                S_WAIT: begin
                    if (cnv_done) begin
                        rdata <= cnv_data;
                        state <= S_WRITE;
                    end
                end
                S_WRITE: state <= S_DISP;
                default: state <= S_DISP;
            endcase
        end
    end

    a_r2_resolve_after_final: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3 && $past(phase) != 2'd3) |-> ($past(phase) == 2'd2));

    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> (!cnv_start && phase == 2'd3));

    a_r6_end_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_end) |=> !cnv_start);

    a_r4_write_once: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |=> !res_we);
endmodule

// File: rtl/qadc_seq.sv
// Module: top of the queued conversion sequencer. Instantiates two queue
// controllers and the engine, and derives the queue limits and the interrupt.
// Assumes bq2 values above DEPTH mean "queue 2 empty".
module qadc_seq
    import qseq_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int AW       = $clog2(DEPTH),
    parameter int RES_W    = 10,
    parameter int INIT_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       trig,
    input  logic [1:0]       en_set,
    input  logic [1:0]       en_clr,
    input  logic [1:0]       cont,
    input  logic [AW:0]      bq2,
    input  logic [1:0]       pause_ie,
    input  logic [1:0]       done_ie,
    input  logic [5:0]       flag_clr,
    output logic [AW-1:0]    cmd_addr,
    input  logic [8:0]       cmd_word,
    output logic             res_we,
    output logic [AW-1:0]    res_addr,
    output logic [RES_W-1:0] res_data,
    output logic [1:0]       cnv_phase,
    output logic             cnv_start,
    output logic [5:0]       cnv_chan,
    input  logic             cnv_done,
    input  logic [RES_W-1:0] cnv_data,
    output logic [1:0]       q_active,
    output logic [1:0]       q_en,
    output logic [1:0]       pause_flag,
    output logic [1:0]       done_flag,
    output logic [1:0]       overrun_flag,
    output logic             irq
);
    localparam logic [AW:0] TOP = (AW+1)'(DEPTH);

    logic [AW:0] bq2_eff;
    logic [AW:0] qptr  [2];
    logic [AW:0] qstart[2];
    logic [1:0]  qhold;
    logic [1:0]  ev_end;
    logic [1:0]  ev_adv;
    logic        ev_pause;

    // Clamp the queue boundary into the RAM and form each queue's first index.
    always_comb begin
        bq2_eff   = (bq2 > TOP) ? TOP : bq2;
        qstart[0] = '0;
        qstart[1] = bq2_eff;
    end

    for (genvar q = 0; q < 2; q++) begin : g_queue
        qseq_queue #(.DEPTH(DEPTH), .AW(AW)) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig      (trig[q]),
            .en_set    (en_set[q]),
            .en_clr    (en_clr[q]),
            .cont      (cont[q]),
            .start_idx (qstart[q]),
            .ev_end    (ev_end[q]),
            .ev_adv    (ev_adv[q]),
            .ev_pause  (ev_pause),
            .clr_pf    (flag_clr[q]),
            .clr_cf    (flag_clr[2+q]),
            .clr_tor   (flag_clr[4+q]),
            .run       (q_active[q]),
            .hold      (qhold[q]),
            .ptr       (qptr[q]),
            .en        (q_en[q]),
            .pf        (pause_flag[q]),
            .cf        (done_flag[q]),
            .tor       (overrun_flag[q])
        );
    end

    qseq_engine #(.DEPTH(DEPTH), .AW(AW), .RES_W(RES_W), .INIT_CYC(INIT_CYC)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_run     (q_active),
        .q_hold    (qhold),
        .ptr_a     (qptr[0]),
        .ptr_b     (qptr[1]),
        .lim_a     (bq2_eff),
        .lim_b     (TOP),
        .cmd_addr  (cmd_addr),
        .cmd_word  (cmd_word),
        .ev_end    (ev_end),
        .ev_adv    (ev_adv),
        .ev_pause  (ev_pause),
        .phase     (cnv_phase),
        .cnv_start (cnv_start),
        .cnv_chan  (cnv_chan),
        .cnv_done  (cnv_done),
        .cnv_data  (cnv_data),
        .res_we    (res_we),
        .res_addr  (res_addr),
        .res_data  (res_data)
    );

    // Interrupt request from the enabled pause and done flags.
    always_comb irq = |(pause_flag & pause_ie) | |(done_flag & done_ie);

    a_r10_q1_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q_active[0] && !qhold[0]) |-> !ev_end[1]);
endmodule

// File: tb/sim_qadc_seq.sv
module sim_qadc_seq;
    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int RW    = 10;
    localparam int INIT  = 2;
    localparam logic [RW-1:0] SENT = 10'h3FF;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [1:0]    trig = '0, en_set = '0, en_clr = '0, cont = '0;
    logic [AW:0]   bq2 = 4'd8;
    logic [1:0]    pause_ie = '0, done_ie = '0;
    logic [5:0]    flag_clr = '0;
    logic [AW-1:0] cmd_addr;
    logic [8:0]    cmd_word;
    logic          res_we;
    logic [AW-1:0] res_addr;
    logic [RW-1:0] res_data;
    logic [1:0]    cnv_phase;
    logic          cnv_start;
    logic [5:0]    cnv_chan;
    logic          cnv_done = 1'b0;
    logic [RW-1:0] cnv_data = '0;
    logic [1:0]    q_active, q_en, pause_flag, done_flag, overrun_flag;
    logic          irq;

    qadc_seq #(.DEPTH(DEPTH), .AW(AW), .RES_W(RW), .INIT_CYC(INIT)) u0 (.*);

    logic [8:0]    cmd_mem [DEPTH];
    logic [RW-1:0] res_mem [DEPTH];
    int log_idx [64];
    int nlog, nstart, ph1, ph2, lat, cd, pend;
    logic [5:0] pch;
    int total = 0, bad = 0;

    assign cmd_word = cmd_mem[cmd_addr];

    function automatic logic [RW-1:0] cval(input logic [5:0] ch);
        return RW'((int'(ch) * 13 + 7) % 1024);
    endfunction

    function automatic logic [8:0] mk(input bit p, input int code, input int ch);
        return {p, 2'(code), 6'(ch)};
    endfunction

    // Converter model and result RAM, evaluated away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_we) begin
                res_mem[res_addr] = res_data;
                if (nlog < 64) log_idx[nlog] = int'(res_addr);
                nlog++;
            end
            if (cnv_phase == 2'd1) ph1++;
            if (cnv_phase == 2'd2) ph2++;
            cnv_done = 1'b0;
            if (pend != 0) begin
                if (cd == 0) begin
                    cnv_done = 1'b1;
                    cnv_data = cval(pch);
                    pend = 0;
                end else cd--;
            end
            if (cnv_start) begin
                nstart++;
                pend = 1;
                cd = lat;
                pch = cnv_chan;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_log();
        for (int i = 0; i < DEPTH; i++) res_mem[i] = SENT;
        nlog = 0; nstart = 0; ph1 = 0; ph2 = 0;
    endtask

    task automatic pulse_trig(input int q);
        @(negedge clk); trig[q] = 1'b1;
        @(negedge clk); trig = '0;
    endtask

    task automatic arm(input int q);
        @(negedge clk); en_set[q] = 1'b1;
        @(negedge clk); en_set = '0;
    endtask

    task automatic clr_all();
        @(negedge clk); flag_clr = '1;
        @(negedge clk); flag_clr = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && q_active != 2'b00; i++) @(negedge clk);
        cyc(2);
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 4000 && nlog < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        lat = 1; pend = 0; cd = 0; pch = '0;
        for (int i = 0; i < DEPTH; i++) cmd_mem[i] = 9'h03F;
        reset_log();
        cyc(4);
        // R1: reset state
        chk(cnv_phase == 0 && !cnv_start && !res_we, "R1 outputs", int'(cnv_phase), 0);
        chk(pause_flag == 0 && done_flag == 0 && overrun_flag == 0 && !irq,
            "R1 flags", int'({pause_flag, done_flag, overrun_flag}), 0);
        chk(q_en == 0 && q_active == 0, "R1 queues", int'({q_en, q_active}), 0);
        rst_n = 1'b1;
        cyc(2);

        // R2 R3: sample-time sweep over every code
        for (int c = 0; c < 4; c++) begin
            cmd_mem[0] = mk(0, c, 5);
            cmd_mem[1] = 9'h03F;
            reset_log();
            arm(0);
            pulse_trig(0);
            wait_idle();
            chk(ph1 == INIT, "R2 initial phase cycles", ph1, INIT);
            chk(ph2 == (2 << c), "R3 final phase cycles", ph2, 2 << c);
            chk(nstart == 1, "R2 one start pulse", nstart, 1);
            chk(res_mem[0] == cval(6'd5), "R4 result value", int'(res_mem[0]), int'(cval(6'd5)));
            chk(q_en[0] == 1'b0, "R9 single scan disarms", int'(q_en[0]), 0);
            clr_all();
        end

        // R4 R8: whole RAM as queue 1, ends at top
        for (int i = 0; i < DEPTH; i++) cmd_mem[i] = mk(0, i % 4, 10 + i);
        lat = 3;
        reset_log();
        arm(0);
        pulse_trig(0);
        wait_idle();
        chk(nlog == DEPTH, "R8 converts through last index", nlog, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            chk(res_mem[i] == cval(6'(10 + i)), "R4 index and data", int'(res_mem[i]), int'(cval(6'(10 + i))));
            chk(log_idx[i] == i, "R4 order", log_idx[i], i);
        end
        chk(done_flag[0] == 1'b1, "R8 done flag", int'(done_flag[0]), 1);
        clr_all();

        // R6: end marker at index 3
        cmd_mem[3] = 9'h03F;
        reset_log();
        arm(0);
        pulse_trig(0);
        wait_idle();
        chk(nstart == 3, "R6 no conversion for marker", nstart, 3);
        chk(res_mem[3] == SENT && res_mem[4] == SENT, "R6 marker index untouched", int'(res_mem[3]), int'(SENT));
        chk(done_flag[0] == 1'b1, "R6 done flag", int'(done_flag[0]), 1);
        clr_all();

        // R7: boundary at 4, queue 1 then queue 2; R12 done interrupt
        for (int i = 0; i < DEPTH; i++) cmd_mem[i] = mk(0, 0, 20 + i);
        bq2 = 4'd4;
        lat = 0;
        reset_log();
        arm(0);
        pulse_trig(0);
        wait_idle();
        chk(nlog == 4 && res_mem[4] == SENT, "R7 queue 1 stops at boundary", nlog, 4);
        chk(done_flag == 2'b01, "R7 queue 1 done only", int'(done_flag), 1);
        done_ie = 2'b10;
        cyc(1);
        chk(irq == 1'b0, "R12 masked done", int'(irq), 0);
        arm(1);
        pulse_trig(1);
        wait_idle();
        chk(nlog == 8 && log_idx[4] == 4 && log_idx[7] == 7, "R7 queue 2 span", nlog, 8);
        chk(done_flag[1] == 1'b1 && irq == 1'b1, "R12 done interrupt", int'(irq), 1);
        done_ie = '0;
        clr_all();
        chk(irq == 1'b0 && done_flag == 0, "R12 flag clear", int'(done_flag), 0);

        // R5 R12: pause at index 1, end marker at 4
        bq2 = 4'd8;
        cmd_mem[1] = mk(1, 0, 21);
        cmd_mem[4] = 9'h03F;
        reset_log();
        arm(0);
        pulse_trig(0);
        for (int i = 0; i < 4000 && !pause_flag[0]; i++) @(negedge clk);
        cyc(40);
        chk(nlog == 2 && q_active[0] == 1'b1, "R5 halted after pause word", nlog, 2);
        chk(irq == 1'b0, "R12 masked pause", int'(irq), 0);
        pause_ie = 2'b01;
        cyc(1);
        chk(irq == 1'b1, "R12 pause interrupt", int'(irq), 1);
        clr_all();
        chk(irq == 1'b0, "R12 pause clear", int'(irq), 0);
        pause_ie = '0;
        pulse_trig(0);
        wait_idle();
        chk(nlog == 4 && log_idx[2] == 2 && log_idx[3] == 3, "R5 resume at next index", nlog, 4);
        clr_all();

        // R11: retrigger while running, then trigger while unarmed
        cmd_mem[1] = mk(0, 3, 21);
        reset_log();
        arm(0);
        pulse_trig(0);
        cyc(10);
        pulse_trig(0);
        cyc(1);
        chk(overrun_flag == 2'b01, "R11 overrun flag", int'(overrun_flag), 1);
        wait_idle();
        chk(nlog == 4, "R11 pass unchanged", nlog, 4);
        clr_all();
        reset_log();
        pulse_trig(0);
        cyc(30);
        chk(nstart == 0 && q_active == 0, "R11 unarmed trigger ignored", nstart, 0);

        // R10: queue 1 preempts queue 2 at a command boundary
        for (int i = 0; i < DEPTH; i++) cmd_mem[i] = mk(0, (i < 3) ? 0 : 3, 30 + i);
        bq2 = 4'd3;
        reset_log();
        arm(0);
        arm(1);
        pulse_trig(1);
        wait_log(1);
        cyc(3);
        pulse_trig(0);
        wait_idle();
        begin
            int exp_ord [8] = '{3, 4, 0, 1, 2, 5, 6, 7};
            chk(nlog == 8, "R10 write count", nlog, 8);
            for (int i = 0; i < 8; i++)
                chk(log_idx[i] == exp_ord[i], "R10 write order", log_idx[i], exp_ord[i]);
        end
        clr_all();

        // R9: continuous scan repeats until disarmed
        bq2 = 4'd2;
        cont = 2'b01;
        reset_log();
        arm(0);
        pulse_trig(0);
        wait_log(5);
        chk(q_en[0] == 1'b1 && q_active[0] == 1'b1, "R9 continuous stays armed", int'(q_en[0]), 1);
        @(negedge clk); en_clr = 2'b01;
        @(negedge clk); en_clr = '0;
        wait_idle();
        chk(nlog >= 6 && (nlog % 2) == 0, "R9 stops at pass end", nlog % 2, 0);
        chk(q_en[0] == 1'b0 && done_flag[0] == 1'b1, "R9 disarmed done", int'(q_en[0]), 0);
        cont = '0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule